// File: doc/BRIEF.md
# Two-Pass 8x8 Inverse DCT Engine

This block turns one 8x8 block of frequency coefficients into 64 spatial samples. It uses the separable form of the transform. Coefficients arrive one per beat on a valid/ready stream. The first beat of a block carries a start flag, and beats are taken in row-major order. The engine sends all eight rows, one per cycle, through a single pipelined 8-point transform unit. The unit returns full-precision row results, and these are written back into the same 64-entry buffer that held the coefficients.

Once the last row result has been written back, the controller switches the shared unit to its column mode. It reads the buffer column by column, which transposes it, and sends the eight columns back-to-back. The rounded column results are written back in place. The 64 samples are then streamed out in row-major order, one per cycle. The 64th sample carries an end-of-block flag.

The input is held off while a block is inside the engine. The next block is accepted from the cycle after the last sample leaves.

Control is a six-state machine:
- `ST_LOAD` takes coefficients and moves to `ST_ROWS` on the 64th.
- `ST_ROWS` issues rows 0..7 and moves to `ST_ROW_DRAIN` after row 7.
- `ST_ROW_DRAIN` waits for the pipeline to empty and then moves to `ST_COLS`.
- `ST_COLS` issues columns 0..7 and moves to `ST_COL_DRAIN` after column 7.
- `ST_COL_DRAIN` waits for the pipeline to empty and then moves to `ST_EMIT`.
- `ST_EMIT` streams 64 samples and returns to `ST_LOAD` after the last one.

Top module: `idct2d_rowcol`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: A coefficient is taken only on a cycle with `in_valid` and `in_ready` both high. A block begins only on a beat with `in_start`=1, which is stored as element 0. Beats with `in_start`=0 before any block has begun are discarded.
- R3: A beat with `in_start`=1 while a block is partly loaded restarts loading at element 0, and the earlier partial data is ignored.
- R4: `in_ready` is 0 from the cycle after the 64th coefficient is accepted until the last sample has been emitted, and it is 1 again in the following cycle. `in_ready` and `out_valid` are never both high.
- R5: The eight rows are issued on eight consecutive cycles with no rounding, so row results keep every fractional bit.
- R6: The column pass starts only after the last row result has been written back and the pipeline is empty. With back-to-back passes, the first sample appears exactly 22 cycles after the cycle that follows acceptance of the 64th coefficient.
- R7: Column mode rounds half-up to an integer: (sum + 2^29) >> 30 arithmetically. A block whose only non-zero coefficient is element 0 = 1024 yields 128 at every position.
- R8: Samples leave in row-major order (element index = 8*row + column) on 64 consecutive cycles. `out_last` is 1 only on the 64th.
- R9: For coefficients in [-512, 511], each output sample (16-bit two's complement) is within 1 of the real-valued 2-D inverse DCT, rounded to nearest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient beat present |
| in_ready | output | 1 | Engine can take a coefficient |
| in_start | input | 1 | Beat is element 0 of a new block |
| in_coef | input | IN_W | Signed coefficient |
| out_valid | output | 1 | Sample present |
| out_sample | output | OUT_W | Signed spatial sample |
| out_last | output | 1 | Sample is the 64th of its block |

## Verification
The checker examines these rules on every cycle:
- the input and output handshakes never overlap;
- the end-of-block flag only accompanies a valid sample;
- input opens in the cycle right after the last sample;
- the first column issue always finds the transform pipeline empty.

The numerical result can only be shown by the bench scenarios. These compare every sample against a real-valued reference and check the exact cycle latency that proves both passes run back-to-back. The row-major orientation, start-flag filtering, restart and the ignoring of beats offered while busy are also shown only by the scenarios.

// File: rtl/idct_rc_pkg.sv
package idct_rc_pkg;

    localparam int PTS    = 8;
    localparam int COEF_W = 16;
    localparam int FRAC   = 15;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_ROWS,
        ST_ROW_DRAIN,
        ST_COLS,
        ST_COL_DRAIN,
        ST_EMIT
    } ctl_state_t;

    // Basis weight for frequency k and spatial point j, scaled by 2^FRAC
    // and already including the C(k)/2 normalisation.
    function automatic logic signed [COEF_W-1:0] basis(input int k, input int j);
        int m;
        logic neg;
        logic signed [COEF_W-1:0] mag;
        m   = ((2 * j + 1) * k) % 32;
        if (m > 16) m = 32 - m;
        neg = (m > 8);
        if (neg) m = 16 - m;
        case (m)
            1:       mag = COEF_W'(16069);
            2:       mag = COEF_W'(15137);
            3:       mag = COEF_W'(13623);
            4:       mag = COEF_W'(11585);
            5:       mag = COEF_W'(9102);
            6:       mag = COEF_W'(6270);
            7:       mag = COEF_W'(3196);
            default: mag = '0;
        endcase
        if (k == 0) return COEF_W'(11585);
        return neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/idct8_datapath.sv
module idct8_datapath
    import idct_rc_pkg::*;
#(
    parameter int DW = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_col,
    input  logic [2:0]               in_tag,
    input  logic [PTS-1:0][DW-1:0]   in_vec,
    output logic                     out_valid,
    output logic                     out_col,
    output logic [2:0]               out_tag,
    output logic [PTS-1:0][DW-1:0]   out_vec,
    output logic                     busy
);
    localparam int PW = DW + COEF_W;
    localparam int AW = PW + $clog2(PTS);
    localparam int SH = 2 * FRAC;
    localparam logic signed [AW-1:0] RND = AW'(1) <<< (SH - 1);

    logic                 v1, col1;
    logic [2:0]           tag1;
    logic signed [PW-1:0] prod [PTS][PTS];
    logic signed [AW-1:0] accs [PTS];
    logic [PTS-1:0][DW-1:0] res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            out_valid <= v1;
        end
    end

    always_ff @(posedge clk) begin
        col1    <= in_col;
        tag1    <= in_tag;
        out_col <= col1;
        out_tag <= tag1;
        out_vec <= res;
        for (int j = 0; j < PTS; j++) begin
            for (int k = 0; k < PTS; k++) begin
                prod[j][k] <= PW'($signed(in_vec[k])) * PW'(basis(k, j));
            end
        end
    end

    always_comb begin
        for (int j = 0; j < PTS; j++) begin
            accs[j] = '0;
            for (int k = 0; k < PTS; k++) begin
                accs[j] = accs[j] + AW'(prod[j][k]);
            end
            res[j] = col1 ? DW'((accs[j] + RND) >>> SH) : DW'(accs[j]);
        end
    end

    assign busy = v1 | out_valid;

endmodule

// File: rtl/idct_tbuf.sv
module idct_tbuf
    import idct_rc_pkg::*;
#(
    parameter int DW    = 31,
    parameter int OUT_W = 16
) (
    input  logic                     clk,
    input  logic                     ld_en,
    input  logic [5:0]               ld_idx,
    input  logic [DW-1:0]            ld_val,
    input  logic                     wb_en,
    input  logic                     wb_col,
    input  logic [2:0]               wb_tag,
    input  logic [PTS-1:0][DW-1:0]   wb_vec,
    input  logic                     rd_col,
    input  logic [2:0]               rd_idx,
    output logic [PTS-1:0][DW-1:0]   rd_vec,
    input  logic [5:0]               em_idx,
    output logic [OUT_W-1:0]         em_val
);
    logic [DW-1:0] mem [PTS*PTS];

    always_ff @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_val;
        if (wb_en) begin
            for (int k = 0; k < PTS; k++) begin
                if (wb_col) mem[{3'(k), wb_tag}] <= wb_vec[k];
                else        mem[{wb_tag, 3'(k)}] <= wb_vec[k];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < PTS; k++) begin
            rd_vec[k] = rd_col ? mem[{3'(k), rd_idx}] : mem[{rd_idx, 3'(k)}];
        end
    end

    assign em_val = mem[em_idx][OUT_W-1:0];

endmodule

// File: rtl/idct2d_rowcol.sv
module idct2d_rowcol
    import idct_rc_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_start,
    input  logic [IN_W-1:0]   in_coef,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_sample,
    output logic              out_last
);
    localparam int MID_W = IN_W + COEF_W + $clog2(PTS);
    localparam int NS    = PTS * PTS;
    localparam logic [5:0] LAST_E = 6'(NS - 1);
    localparam logic [2:0] LAST_L = 3'(PTS - 1);

    ctl_state_t state, nxt;
    logic [5:0] cnt;

    logic                      ld_en;
    logic [5:0]                ld_idx;
    logic                      dp_in_valid, dp_in_col, dp_busy;
    logic                      dp_out_valid, dp_out_col;
    logic [2:0]                dp_out_tag;
    logic [PTS-1:0][MID_W-1:0] rd_vec, dp_out_vec;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
            cnt   <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_LOAD:                    if (ld_en) cnt <= ld_idx + 6'd1;
                ST_ROWS, ST_COLS:           cnt <= (cnt[2:0] == LAST_L) ? '0 : cnt + 6'd1;
                ST_ROW_DRAIN, ST_COL_DRAIN: cnt <= '0;
                ST_EMIT:                    cnt <= (cnt == LAST_E) ? '0 : cnt + 6'd1;
                default:                    cnt <= '0;
            endcase
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD:      if (ld_en && ld_idx == LAST_E) nxt = ST_ROWS;
            ST_ROWS:      if (cnt[2:0] == LAST_L)        nxt = ST_ROW_DRAIN;
            ST_ROW_DRAIN: if (!dp_busy)                  nxt = ST_COLS;
            ST_COLS:      if (cnt[2:0] == LAST_L)        nxt = ST_COL_DRAIN;
            ST_COL_DRAIN: if (!dp_busy)                  nxt = ST_EMIT;
            ST_EMIT:      if (cnt == LAST_E)             nxt = ST_LOAD;
            default:                                     nxt = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        in_ready    = (state == ST_LOAD);
        ld_en       = in_ready && in_valid && (in_start || cnt != '0);
        ld_idx      = in_start ? '0 : cnt;
        dp_in_valid = (state == ST_ROWS) || (state == ST_COLS);
        dp_in_col   = (state == ST_COLS);
        out_valid   = (state == ST_EMIT);
        out_last    = out_valid && (cnt == LAST_E);
    end

    idct8_datapath #(.DW(MID_W)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dp_in_valid),
        .in_col    (dp_in_col),
        .in_tag    (cnt[2:0]),
        .in_vec    (rd_vec),
        .out_valid (dp_out_valid),
        .out_col   (dp_out_col),
        .out_tag   (dp_out_tag),
        .out_vec   (dp_out_vec),
        .busy      (dp_busy)
    );

    idct_tbuf #(.DW(MID_W), .OUT_W(OUT_W)) buf_i (
        .clk    (clk),
        .ld_en  (ld_en),
        .ld_idx (ld_idx),
        .ld_val (MID_W'($signed(in_coef))),
        .wb_en  (dp_out_valid),
        .wb_col (dp_out_col),
        .wb_tag (dp_out_tag),
        .wb_vec (dp_out_vec),
        .rd_col (dp_in_col),
        .rd_idx (cnt[2:0]),
        .rd_vec (rd_vec),
        .em_idx (cnt),
        .em_val (out_sample)
    );

endmodule

// File: rtl/idct2d_rowcol_chk.sv
module idct2d_rowcol_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic out_last,
    input logic dp_in_valid,
    input logic dp_in_col,
    input logic dp_busy
);
    // R4
    ready_vs_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R4
    reopen_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> in_ready);

    // R8
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6
    col_start_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_in_valid && dp_in_col && !$past(dp_in_valid && dp_in_col)) |-> !dp_busy);

endmodule

bind idct2d_rowcol idct2d_rowcol_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .dp_in_valid (dp_in_valid),
    .dp_in_col   (dp_in_col),
    .dp_busy     (dp_busy)
);

// File: tb/idct2d_rowcol_tb_top.sv
`timescale 1ns/1ps
module idct2d_rowcol_tb_top;
    localparam int IN_W  = 12;
    localparam int OUT_W = 16;
    localparam real PI   = 3.14159265358979;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_start = 0;
    logic [IN_W-1:0] in_coef = '0;
    logic in_ready, out_valid, out_last;
    logic [OUT_W-1:0] out_sample;

    int checks = 0, fails = 0;
    int blk [64];
    int got [64];

    always #10 clk = ~clk;

    idct2d_rowcol #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_start(in_start), .in_coef(in_coef), .out_valid(out_valid),
        .out_sample(out_sample), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_beat(input int v, input bit s);
        @(negedge clk);
        in_valid = 1'b1;
        in_start = s;
        in_coef  = IN_W'(v);
    endtask

    task automatic send_block();
        for (int i = 0; i < 64; i++) drive_beat(blk[i], i == 0);
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
    endtask

    task automatic collect(input int exp_wait);
        int waited = 0;
        bit ready_seen = 0;
        while (!out_valid && waited < 300) begin
            if (in_ready) ready_seen = 1;
            @(negedge clk);
            waited++;
        end
        chk(!ready_seen, "R4 ready held low while busy", int'(ready_seen), 0);
        if (exp_wait >= 0) chk(waited == exp_wait, "R5/R6 first sample latency", waited, exp_wait);
        for (int i = 0; i < 64; i++) begin
            chk(out_valid == 1'b1, "R8 consecutive samples", int'(out_valid), 1);
            chk(out_last == (i == 63), "R8 end-of-block flag", int'(out_last), int'(i == 63));
            got[i] = int'($signed(out_sample));
            @(negedge clk);
        end
        chk(in_ready == 1'b1, "R4 ready returns after last", int'(in_ready), 1);
    endtask

    function automatic real cn(input int u);
        return (u == 0) ? $sqrt(0.5) : 1.0;
    endfunction

    task automatic compare_ref(input string tag);
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                real acc = 0.0;
                int e, d;
                for (int u = 0; u < 8; u++)
                    for (int v = 0; v < 8; v++)
                        acc += 0.25 * cn(u) * cn(v) * real'(blk[8*u+v])
                             * $cos(real'((2*r+1)*u) * PI / 16.0)
                             * $cos(real'((2*c+1)*v) * PI / 16.0);
                e = $rtoi($floor(acc + 0.5));
                d = got[8*r+c] - e;
                chk(d <= 1 && d >= -1, {"R9 ", tag}, got[8*r+c], e);
            end
        end
    endtask

    task automatic clear_blk();
        for (int i = 0; i < 64; i++) blk[i] = 0;
    endtask

    task automatic rand_blk();
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(1023)) - 512;
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);
    endtask

    task automatic t_dc();
        clear_blk();
        blk[0] = 1024;
        send_block();
        collect(22);
        for (int i = 0; i < 64; i++) chk(got[i] == 128, "R7 dc rounding", got[i], 128);
        compare_ref("dc");
    endtask

    task automatic t_orientation();
        clear_blk();
        blk[1] = 300;   // horizontal frequency 1: varies along columns only
        send_block();
        collect(22);
        compare_ref("R8 row-major orientation");
        clear_blk();
        blk[8] = -300;  // vertical frequency 1
        send_block();
        collect(22);
        compare_ref("R8 vertical orientation");
    endtask

    task automatic t_random(input int n);
        for (int b = 0; b < n; b++) begin
            rand_blk();
            send_block();
            collect(22);
            compare_ref("R5 random block");
        end
    endtask

    task automatic t_prestart();
        rand_blk();
        for (int i = 0; i < 5; i++) drive_beat(2000, 1'b0);
        send_block();
        collect(22);
        compare_ref("R2 beats before start dropped");
    endtask

    task automatic t_restart();
        for (int i = 0; i < 20; i++) drive_beat(1700 - i, i == 0);
        rand_blk();
        send_block();
        collect(22);
        compare_ref("R3 restart on start flag");
    endtask

    task automatic t_busy_offer();
        rand_blk();
        send_block();
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            in_start = 1'b1;
            in_coef  = IN_W'(1500);
            chk(in_ready == 1'b0, "R4 ready low after 64th", int'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_start = 1'b0;
        collect(16);
        compare_ref("R2 busy offers ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dc();
        t_orientation();
        t_random(3);
        t_prestart();
        t_restart();
        t_busy_offer();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule